// File: doc/BRIEF.md
# SPI Flash Block-Erase Sequencer

This block runs one complete block erase on a serial NOR flash attached over SPI. The host hands it a single request naming the block size (32 KB or 64 KB) and a 24-bit byte address. The sequencer sends the erase as a chain of separate chip-select frames:

- a write-enable frame;
- an erase frame holding the size-specific opcode and the block-aligned address;
- as many status-read frames as needed, until the flash reports it is no longer busy or a poll limit is reached.

It then raises a one-cycle completion pulse that carries an error flag.

The request side is a valid/ready stream of one item per erase. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle, so a host holding `req_valid` simply waits. Request fields only need to be stable in the accepting cycle; they are captured there. Completion is a plain pulse with no back-pressure.

The two configuration inputs are sampled while a transaction runs:

- `cfg_desel` sets the minimum chip-select-high time between frames, in clock cycles.
- `cfg_poll_max` caps how many status reads are issued.

The serial clock runs at the system clock divided by twice the `SCK_HALF` parameter.

Top module: `spi_blk_erase_ctrl`

## Requirements
- R1: `req_ready` is high exactly when the sequencer is idle. After an accepting edge it is low from the next cycle through the cycle of `done_valid`, and high again in the cycle after. While `spi_cs_n` is low, `req_ready` is low.
- R2: The first frame of every transaction carries exactly 8 serial clocks, with the write-enable byte 0x06.
- R3: The second frame carries exactly 32 serial clocks. It holds the opcode 0x52 when `req_big`=0 (32 KB) or 0xD8 when `req_big`=1 (64 KB), followed by the address as three bytes, most significant bit first.
- R4: The address sent is block aligned. For 32 KB, bits 23..15 come from the request and bits 14..0 are zero. For 64 KB, bits 23..16 come from the request and bits 15..0 are zero. Address input changes after the accepting edge have no effect.
- R5: Between two frames of one transaction, `spi_cs_n` stays high for at least max(`cfg_desel`,1) cycles. `spi_sck` is low whenever `spi_cs_n` is high.
- R6: SPI mode 0 timing: `spi_sck` idles low. `spi_mosi` changes only while `spi_sck` is low, and is sampled by the flash on the rising edge.
- R7: Each status frame is 16 serial clocks. The first byte is 0x05, and during the second byte the sequencer samples `spi_miso` on rising edges, MSB first. Busy is bit 0 of that byte; the other status bits and `spi_miso` in every other byte have no effect.
- R8: The sequencer waits for the end of the erase frame (chip select high) before its first status frame. Status frames repeat until a read shows busy clear. It then pulses `done_valid` with `done_err`=0, with `spi_cs_n` high.
- R9: If the first max(`cfg_poll_max`,1) status reads all show busy, the sequencer pulses `done_valid` with `done_err`=1 right after the last of them. It issues no further frames.
- R10: `done_valid` lasts exactly one cycle per transaction, and `done_err` is low whenever `done_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_big | input | 1 | 1 = 64 KB block, 0 = 32 KB block |
| req_addr | input | 24 | Any byte address inside the target block |
| cfg_desel | input | DESEL_W | Minimum chip-select-high cycles between frames |
| cfg_poll_max | input | POLL_W | Maximum number of status reads |
| done_valid | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | With done_valid: poll limit reached while busy |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench attacks the poll limit from both sides:

- busy clearing on exactly the last allowed read, which must give a clean completion;
- busy persisting through it, which must give an error with no extra frame;
- a limit of zero, which must behave as one.

A sequencer with an off-by-one in the limit would issue one poll too many or too few, or flag the wrong outcome.

The flash model drives noise on the data-in line outside the status byte, and sets every non-busy status bit. A design that sampled the wrong byte or bit would then stall or finish early.

Unaligned addresses in both block sizes expose missing or wrong low-bit masking. The request address is changed while the request is still held after acceptance, so a design that re-captured it would send the wrong block.

Deselect gaps are measured against several settings, including zero. Mode 0 stability of the data-out line while the clock is high is watched on every cycle, so a skipped gap or a data change on the wrong clock phase shows up as a count mismatch.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_GAP,
    ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    FR_WREN,
    FR_ERASE,
    FR_POLL
  } frame_kind_t;

  localparam logic [7:0] OP_WREN      = 8'h06;
  localparam logic [7:0] OP_RDSR      = 8'h05;
  localparam logic [7:0] OP_ERASE_32K = 8'h52;
  localparam logic [7:0] OP_ERASE_64K = 8'hD8;
  localparam int         BUSY_BIT     = 0;
  localparam int         ADDR_W       = 24;

  // index of the final byte inside each frame kind
  function automatic logic [1:0] frame_last(input frame_kind_t k);
    case (k)
      FR_WREN:  return 2'd0;
      FR_ERASE: return 2'd3;
      default:  return 2'd1;
    endcase
  endfunction

  // byte to shift for a given frame kind and position
  function automatic logic [7:0] frame_byte(input frame_kind_t k, input logic [1:0] idx,
                                            input logic big, input logic [ADDR_W-1:0] addr);
    logic [7:0] b;
    b = 8'h00;
    case (k)
      FR_WREN: b = OP_WREN;
      FR_ERASE: begin
        case (idx)
          2'd0:    b = big ? OP_ERASE_64K : OP_ERASE_32K;
          2'd1:    b = addr[23:16];
          2'd2:    b = addr[15:8];
          default: b = addr[7:0];
        endcase
      end
      default: b = (idx == 2'd0) ? OP_RDSR : 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int HALF_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYC - 1);

  logic             active;
  logic             phase_hi;
  logic [DIV_W-1:0] div_cnt;
  logic [2:0]       bit_cnt;
  logic [7:0]       tx_sh;
  logic [7:0]       rx_sh;

  assign sck     = active & phase_hi;
  assign mosi    = tx_sh[7];
  assign rx_byte = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      phase_hi <= 1'b0;
      div_cnt  <= '0;
      bit_cnt  <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active   <= 1'b1;
        phase_hi <= 1'b0;
        div_cnt  <= '0;
        bit_cnt  <= '0;
        tx_sh    <= tx_byte;
      end else if (active) begin
        if (div_cnt == DIV_LAST) begin
          div_cnt <= '0;
          if (!phase_hi) begin
            // rising edge: capture incoming bit
            phase_hi <= 1'b1;
            rx_sh    <= {rx_sh[6:0], miso};
          end else begin
            // falling edge: launch next bit or finish
            phase_hi <= 1'b0;
            if (bit_cnt == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              tx_sh   <= {tx_sh[6:0], 1'b0};
            end
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import spi_erase_pkg::*;
#(
  parameter int DESEL_W = 8,
  parameter int POLL_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_big,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DESEL_W-1:0] cfg_desel,
  input  logic [POLL_W-1:0]  cfg_poll_max,
  output logic               done_valid,
  output logic               done_err,
  output logic               cs_n,
  output logic               eng_start,
  output logic [7:0]         eng_tx,
  input  logic               eng_done,
  input  logic [7:0]         eng_rx
);
  seq_state_t         state;
  frame_kind_t        kind;
  logic [1:0]         idx;
  logic [ADDR_W-1:0]  addr_q;
  logic               big_q;
  logic [DESEL_W-1:0] gap_cnt;
  logic [POLL_W-1:0]  poll_cnt;
  logic [POLL_W:0]    poll_next;
  logic [ADDR_W-1:0]  addr_aligned;
  logic               last_byte;

  assign req_ready    = (state == ST_IDLE);
  assign poll_next    = {1'b0, poll_cnt} + 1'b1;
  assign last_byte    = (idx == frame_last(kind));
  assign addr_aligned = req_big ? {req_addr[23:16], 16'h0000}
                                : {req_addr[23:15], 15'h0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      kind       <= FR_WREN;
      idx        <= '0;
      addr_q     <= '0;
      big_q      <= 1'b0;
      gap_cnt    <= '0;
      poll_cnt   <= '0;
      cs_n       <= 1'b1;
      eng_start  <= 1'b0;
      eng_tx     <= '0;
      done_valid <= 1'b0;
      done_err   <= 1'b0;
    end else begin
      eng_start  <= 1'b0;
      done_valid <= 1'b0;
      done_err   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q    <= addr_aligned;
            big_q     <= req_big;
            kind      <= FR_WREN;
            idx       <= '0;
            poll_cnt  <= '0;
            cs_n      <= 1'b0;
            eng_start <= 1'b1;
            eng_tx    <= OP_WREN;
            state     <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (eng_done) begin
            if (!last_byte) begin
              idx       <= idx + 2'd1;
              eng_start <= 1'b1;
              eng_tx    <= frame_byte(kind, idx + 2'd1, big_q, addr_q);
            end else begin
              cs_n <= 1'b1;
              case (kind)
                FR_WREN: begin
                  kind    <= FR_ERASE;
                  gap_cnt <= cfg_desel;
                  state   <= ST_GAP;
                end
                FR_ERASE: begin
                  kind    <= FR_POLL;
                  gap_cnt <= cfg_desel;
                  state   <= ST_GAP;
                end
                default: begin
                  if (!eng_rx[BUSY_BIT]) begin
                    done_valid <= 1'b1;
                    state      <= ST_DONE;
                  end else if (poll_next >= {1'b0, cfg_poll_max}) begin
                    done_valid <= 1'b1;
                    done_err   <= 1'b1;
                    state      <= ST_DONE;
                  end else begin
                    poll_cnt <= poll_next[POLL_W-1:0];
                    gap_cnt  <= cfg_desel;
                    state    <= ST_GAP;
                  end
                end
              endcase
            end
          end
        end
        ST_GAP: begin
          if (gap_cnt <= DESEL_W'(1)) begin
            cs_n      <= 1'b0;
            idx       <= '0;
            eng_start <= 1'b1;
            eng_tx    <= frame_byte(kind, 2'd0, big_q, addr_q);
            state     <= ST_XFER;
          end else begin
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_blk_erase_ctrl.sv
module spi_blk_erase_ctrl #(
  parameter int SCK_HALF = 2,
  parameter int DESEL_W  = 8,
  parameter int POLL_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_big,
  input  logic [23:0]        req_addr,
  input  logic [DESEL_W-1:0] cfg_desel,
  input  logic [POLL_W-1:0]  cfg_poll_max,
  output logic               done_valid,
  output logic               done_err,
  output logic               spi_sck,
  output logic               spi_cs_n,
  output logic               spi_mosi,
  input  logic               spi_miso
);
  logic       eng_start;
  logic [7:0] eng_tx;
  logic       eng_done;
  logic [7:0] eng_rx;

  erase_seq_ctrl #(
    .DESEL_W(DESEL_W),
    .POLL_W (POLL_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_big     (req_big),
    .req_addr    (req_addr),
    .cfg_desel   (cfg_desel),
    .cfg_poll_max(cfg_poll_max),
    .done_valid  (done_valid),
    .done_err    (done_err),
    .cs_n        (spi_cs_n),
    .eng_start   (eng_start),
    .eng_tx      (eng_tx),
    .eng_done    (eng_done),
    .eng_rx      (eng_rx)
  );

  spi_shift_engine #(
    .HALF_CYC(SCK_HALF)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (eng_start),
    .tx_byte(eng_tx),
    .miso   (spi_miso),
    .sck    (spi_sck),
    .mosi   (spi_mosi),
    .done   (eng_done),
    .rx_byte(eng_rx)
  );

endmodule

// File: rtl/spi_blk_erase_chk.sv
module spi_blk_erase_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done_valid,
  input logic done_err,
  input logic spi_sck,
  input logic spi_cs_n,
  input logic spi_mosi
);

  assert_sck_low_deselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  assert_mosi_stable_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> (spi_mosi == $past(spi_mosi)));

  assert_not_ready_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !req_ready);

  assert_accept_drops_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_done_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  assert_err_only_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done_valid);

  assert_done_after_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> spi_cs_n);

endmodule

bind spi_blk_erase_ctrl spi_blk_erase_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done_valid(done_valid),
  .done_err  (done_err),
  .spi_sck   (spi_sck),
  .spi_cs_n  (spi_cs_n),
  .spi_mosi  (spi_mosi)
);

// File: tb/spi_blk_erase_ctrl_tb_top.sv
module spi_blk_erase_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_big = 1'b0;
  logic [23:0] req_addr = '0;
  logic [7:0]  cfg_desel = 8'd2;
  logic [15:0] cfg_poll_max = 16'd8;
  logic        spi_miso = 1'b1;
  logic        req_ready, done_valid, done_err, spi_sck, spi_cs_n, spi_mosi;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_blk_erase_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_big(req_big), .req_addr(req_addr), .cfg_desel(cfg_desel),
    .cfg_poll_max(cfg_poll_max), .done_valid(done_valid), .done_err(done_err),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model and flash-side monitor state
  int         cyc = 0;
  bit         model_busy = 0;
  bit         prev_cs = 1, prev_sck = 0, prev_mosi = 0;
  int         bits = 0, hi_cnt = 0, txn_frames = 0, poll_idx = 0, busy_polls = 0;
  int         gap_min = 1;
  logic [7:0] cur_byte = '0, first_byte = '0;
  int         frame_bits[$];
  logic [7:0] frame_bytes[$];
  int         ready_err = 0, sck_err = 0, gap_err = 0, mosi_err = 0, done_cnt = 0, err_leak = 0;
  bit         done_seen = 0, done_err_seen = 0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
    if (rst_n) begin
      if (req_ready !== !model_busy) ready_err++;   // R1 cycle model
      if (spi_cs_n && spi_sck) sck_err++;           // R5
      if (spi_sck && prev_sck && spi_mosi != prev_mosi) mosi_err++;  // R6
      if (!done_valid && done_err) err_leak++;      // R10
      if (prev_cs && !spi_cs_n) begin
        if (txn_frames > 0 && hi_cnt < gap_min) gap_err++;
        bits = 0;
        first_byte = '0;
      end
      if (!spi_cs_n && spi_sck && !prev_sck) begin
        cur_byte = {cur_byte[6:0], spi_mosi};
        bits++;
        if (bits % 8 == 0) frame_bytes.push_back(cur_byte);
        if (bits == 8) first_byte = cur_byte;
      end
      if (!prev_cs && spi_cs_n) begin
        frame_bits.push_back(bits);
        txn_frames++;
        if (first_byte == 8'h05) poll_idx++;
        hi_cnt = 0;
      end
      if (spi_cs_n) hi_cnt++;
      // flash response: status byte during a read-status frame, noise elsewhere
      if (!spi_cs_n && first_byte == 8'h05 && bits >= 8 && bits < 16) begin
        logic [7:0] st;
        st = (poll_idx < busy_polls) ? 8'h1D : 8'hFE;
        spi_miso = st[15 - bits];
      end else begin
        spi_miso = cyc[0] ^ cyc[2];
      end
      if (req_valid && req_ready) model_busy = 1;
      if (done_valid) begin
        model_busy = 0;
        done_seen = 1;
        done_err_seen = done_err;
        done_cnt++;
      end
    end
    prev_cs = spi_cs_n;
    prev_sck = spi_sck;
    prev_mosi = spi_mosi;
  end

  task automatic run_erase(input bit big, input logic [23:0] addr, input int busy_n,
                           input int desel, input int pmax, input int hold, input string name);
    int lim, polls, nframes, t, poll_bad;
    bit exp_err;
    logic [23:0] exp_addr;
    logic [7:0] exp_op;
    @(posedge clk); #1;
    cfg_desel = 8'(desel);
    cfg_poll_max = 16'(pmax);
    gap_min = (desel < 1) ? 1 : desel;
    frame_bits.delete();
    frame_bytes.delete();
    txn_frames = 0; poll_idx = 0; busy_polls = busy_n;
    ready_err = 0; sck_err = 0; gap_err = 0; mosi_err = 0; done_cnt = 0; err_leak = 0;
    done_seen = 0;
    req_big = big;
    req_addr = addr;
    req_valid = 1'b1;
    @(posedge clk); #1;
    // keep valid high while the block is busy and scramble the address: no effect (R1, R4)
    req_addr = ~addr;
    req_big = ~big;
    repeat (hold) begin @(posedge clk); #1; end
    req_valid = 1'b0;
    t = 0;
    while (!done_seen && t < 40000) begin @(negedge clk); t++; end
    repeat (60) @(negedge clk);

    lim = (pmax < 1) ? 1 : pmax;
    exp_err = (busy_n >= lim);
    polls = exp_err ? lim : busy_n + 1;
    nframes = 2 + polls;
    exp_op = big ? 8'hD8 : 8'h52;
    exp_addr = big ? {addr[23:16], 16'h0} : {addr[23:15], 15'h0};

    check(done_seen, exp_err ? "R9" : "R8", {name, " done seen"}, done_seen, 1);
    check(done_err_seen == exp_err, exp_err ? "R9" : "R8", {name, " error flag"}, done_err_seen, exp_err);
    check(frame_bits.size() == nframes, exp_err ? "R9" : "R8", {name, " frame count"}, frame_bits.size(), nframes);
    if (frame_bits.size() >= 2 && frame_bytes.size() >= 5) begin
      check(frame_bits[0] == 8 && frame_bytes[0] == 8'h06, "R2", {name, " write-enable frame"},
            frame_bytes[0], 8'h06);
      check(frame_bits[1] == 32, "R3", {name, " erase frame clocks"}, frame_bits[1], 32);
      check(frame_bytes[1] == exp_op, "R3", {name, " erase opcode"}, frame_bytes[1], exp_op);
      check({frame_bytes[2], frame_bytes[3], frame_bytes[4]} == exp_addr, "R4", {name, " address"},
            {frame_bytes[2], frame_bytes[3], frame_bytes[4]}, exp_addr);
    end else begin
      check(0, "R3", {name, " erase frame missing"}, frame_bits.size(), 2);
    end
    poll_bad = 0;
    for (int i = 0; i < polls; i++) begin
      if (2 + i >= frame_bits.size() || 5 + 2 * i >= frame_bytes.size()) poll_bad++;
      else if (frame_bits[2 + i] != 16 || frame_bytes[5 + 2 * i] != 8'h05) poll_bad++;
    end
    check(poll_bad == 0, "R7", {name, " status frames"}, poll_bad, 0);
    check(gap_err == 0 && sck_err == 0, "R5", {name, " deselect gaps"}, gap_err + sck_err, 0);
    check(mosi_err == 0, "R6", {name, " data stable while clock high"}, mosi_err, 0);
    check(ready_err == 0, "R1", {name, " ready vs model"}, ready_err, 0);
    check(done_cnt == 1 && err_leak == 0, "R10", {name, " done pulse"}, done_cnt, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R5", "bus idle in reset", {spi_cs_n, spi_sck}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && done_valid == 1'b0, "R1", "idle after reset", req_ready, 1);
    check(spi_sck == 1'b0, "R6", "clock idles low", spi_sck, 0);

    run_erase(1'b0, 24'h12FFFF, 2, 3, 10, 5, "32K unaligned");
    run_erase(1'b1, 24'h7ABCDE, 0, 0, 8, 0, "64K first poll clear");
    run_erase(1'b0, 24'h3C4321, 20, 2, 4, 2, "timeout");
    run_erase(1'b1, 24'h018000, 1, 1, 0, 0, "limit zero");
    run_erase(1'b0, 24'hF9A5A5, 2, 7, 3, 1, "clear on last poll");
    run_erase(1'b1, 24'hFFFFFF, 3, 5, 4, 0, "top block");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule